// File: doc/BRIEF.md
# Error Status and Reporting Logger

This block is the per-function error logging and reporting unit. Other logic sends it single-cycle event pulses, one line per correctable error type and one line per uncorrectable error type. For each event the block records a sticky status bit. It then uses mask, severity and device-level enable registers to decide whether an outgoing error message is needed, and which class it belongs to: correctable, non-fatal or fatal. Software reads the status bits and clears them by writing ones.

Status recording and message generation are kept apart. Status bits latch every event, whatever the mask or enable settings. Masks, severities and enables affect only the message path and the header-log valid flag.

An uncorrectable event can be flagged as advisory. This covers an error seen by an intermediate receiver, or a poisoned payload the final receiver can tolerate. When such an event has non-fatal severity, it is downgraded to a correctable message. One uncorrectable index is reserved for unsupported requests, which need a further enable before a non-fatal message goes out.

Message requests wait in one pending flag per class. They leave on a single valid/ready output, highest class first.

Top module: `err_report_logger`

## Requirements
- R1: An event on correctable line i sets bit i of the correctable status register (address 0). An event on uncorrectable line i sets bit i of the uncorrectable status register (address 2). Both happen on the next clock edge, whatever the mask, severity and enable values.
- R2: The status registers at addresses 0, 2, 6 and 7 clear only where software writes a 1. Writing 0 to a bit leaves it unchanged. If an event sets a bit in the same cycle that a write clears it, the bit ends up set.
- R3: The correctable mask (address 1), uncorrectable mask (address 3), severity (address 4, 1 = fatal) and control (address 5) registers read back what was written. After reset every register reads 0, so all severities start as non-fatal, and no message is pending.
- R4: When an event's mask bit is set, the event produces no message request and does not set the header-log valid flag.
- R5: An unmasked, non-advisory uncorrectable event requests a fatal message when its severity bit is 1 and control bit 2 (fatal enable) is set. It requests a non-fatal message when its severity bit is 0 and control bit 1 (non-fatal enable) is set. An unmasked correctable event requests a correctable message when control bit 0 is set.
- R6: The device status register (address 6) has bit 0 for correctable detected, bit 1 for non-fatal detected, bit 2 for fatal detected and bit 3 for unsupported request detected. These bits are set by events whatever the masks and enables.
- R7: An event on the unsupported-request line (uncorrectable index UR_IDX, default 4) with non-fatal severity sets device status bits 3 and 1. It requests a non-fatal message only when both control bit 1 and control bit 3 (unsupported-request enable) are set.
- R8: An uncorrectable event whose advisory input is high and whose severity is non-fatal sets device status bit 0 but not bit 1. If it is unmasked, it requests a correctable message when control bit 0 is set.
- R9: An advisory-flagged event with fatal severity is handled as fatal. It sets device status bit 2 and, if unmasked, requests a fatal message when control bit 2 is set.
- R10: There is one pending flag per class. Message class codes are 0 = correctable, 1 = non-fatal and 2 = fatal. The output presents the highest pending class, fatal first, then non-fatal, then correctable. The valid signal stays high until a cycle in which ready is high, and that cycle retires the presented class.
- R11: Any unmasked uncorrectable event sets the header-log valid flag, read as bit 0 of address 7. The flag is cleared by writing 1 to that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cor_evt_i | input | NCOR | Correctable error event pulses |
| unc_evt_i | input | NUNC | Uncorrectable error event pulses |
| adv_i | input | NUNC | Advisory qualifier for each uncorrectable event |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address for both read and write |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Register read data, combinational from the addressed register |
| msg_valid_o | output | 1 | An error message request is presented |
| msg_class_o | output | 2 | Class of the presented message |
| msg_ready_i | input | 1 | The message consumer accepts the request |

## Verification
On every cycle the assertions check four things:
- status bits latch their events;
- status bits never drop without a clearing write;
- a presented message stays valid until it is accepted, and its class code is legal;
- an enabled fatal event appears as the fatal class on the next cycle, and an unmasked uncorrectable event raises the header-log flag.

The interplay of masks, enables, the unsupported-request gate and advisory downgrading can only be shown by the bench scenarios. The same is true of same-cycle set-versus-clear and the order in which several pending classes drain. The bench drives these while comparing every read and every message cycle against its own model.

// File: rtl/elog_pkg.sv
package elog_pkg;

    localparam int AW = 3;

    localparam logic [AW-1:0] A_COR_STS = 3'd0;
    localparam logic [AW-1:0] A_COR_MSK = 3'd1;
    localparam logic [AW-1:0] A_UNC_STS = 3'd2;
    localparam logic [AW-1:0] A_UNC_MSK = 3'd3;
    localparam logic [AW-1:0] A_UNC_SEV = 3'd4;
    localparam logic [AW-1:0] A_CTL     = 3'd5;
    localparam logic [AW-1:0] A_DEV_STS = 3'd6;
    localparam logic [AW-1:0] A_HDR     = 3'd7;

    // bit positions shared by the control and device status registers
    localparam int B_COR = 0;
    localparam int B_NF  = 1;
    localparam int B_FAT = 2;
    localparam int B_UR  = 3;
    localparam int NCLS  = 3;

    typedef enum logic [1:0] {
        MSG_COR = 2'd0,
        MSG_NF  = 2'd1,
        MSG_FAT = 2'd2
    } msg_cls_e;

endpackage

// File: rtl/elog_classify.sv
module elog_classify
    import elog_pkg::*;
#(
    parameter int NCOR   = 6,
    parameter int NUNC   = 8,
    parameter int UR_IDX = 4
) (
    input  logic [NCOR-1:0] cor_evt,
    input  logic [NUNC-1:0] unc_evt,
    input  logic [NUNC-1:0] adv,
    input  logic [NCOR-1:0] cor_msk,
    input  logic [NUNC-1:0] unc_msk,
    input  logic [NUNC-1:0] unc_sev,
    input  logic [3:0]      ctl,
    output logic [NCLS-1:0] req,
    output logic [3:0]      det_set,
    output logic            hdr_set
);

    always_comb begin
        req     = '0;
        det_set = '0;
        hdr_set = 1'b0;
        for (int i = 0; i < NCOR; i++) begin
            if (cor_evt[i]) begin
                det_set[B_COR] = 1'b1;
                if (!cor_msk[i] && ctl[B_COR]) req[B_COR] = 1'b1;
            end
        end
        for (int i = 0; i < NUNC; i++) begin
            if (unc_evt[i]) begin
                if (!unc_msk[i]) hdr_set = 1'b1;
                if (i == UR_IDX) det_set[B_UR] = 1'b1;
                if (unc_sev[i]) begin
                    det_set[B_FAT] = 1'b1;
                    if (!unc_msk[i] && ctl[B_FAT]) req[B_FAT] = 1'b1;
                end else if (adv[i]) begin
                    det_set[B_COR] = 1'b1;
                    if (!unc_msk[i] && ctl[B_COR]) req[B_COR] = 1'b1;
                end else begin
                    det_set[B_NF] = 1'b1;
                    if (!unc_msk[i] && ctl[B_NF] && (i != UR_IDX || ctl[B_UR]))
                        req[B_NF] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/elog_regs.sv
module elog_regs
    import elog_pkg::*;
#(
    parameter int DW   = 32,
    parameter int NCOR = 6,
    parameter int NUNC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    input  logic [NCOR-1:0] cor_evt,
    input  logic [NUNC-1:0] unc_evt,
    input  logic [3:0]      det_set,
    input  logic            hdr_set,
    output logic [DW-1:0]   rdata,
    output logic [NCOR-1:0] cor_sts,
    output logic [NCOR-1:0] cor_msk,
    output logic [NUNC-1:0] unc_sts,
    output logic [NUNC-1:0] unc_msk,
    output logic [NUNC-1:0] unc_sev,
    output logic [3:0]      ctl,
    output logic [3:0]      dev_sts,
    output logic            hdr_vld
);

    typedef struct packed {
        logic [NCOR-1:0] cor_sts;
        logic [NCOR-1:0] cor_msk;
        logic [NUNC-1:0] unc_sts;
        logic [NUNC-1:0] unc_msk;
        logic [NUNC-1:0] unc_sev;
        logic [3:0]      ctl;
        logic [3:0]      dev_sts;
        logic            hdr;
    } regs_t;

    regs_t r_d, r_q;

    logic unused_wdata;
    assign unused_wdata = ^wdata;

    always_comb begin
        r_d = r_q;
        // software side: plain writes and write-one-to-clear
        if (wr) begin
            unique case (addr)
                A_COR_STS: r_d.cor_sts = r_q.cor_sts & ~wdata[NCOR-1:0];
                A_COR_MSK: r_d.cor_msk = wdata[NCOR-1:0];
                A_UNC_STS: r_d.unc_sts = r_q.unc_sts & ~wdata[NUNC-1:0];
                A_UNC_MSK: r_d.unc_msk = wdata[NUNC-1:0];
                A_UNC_SEV: r_d.unc_sev = wdata[NUNC-1:0];
                A_CTL:     r_d.ctl     = wdata[3:0];
                A_DEV_STS: r_d.dev_sts = r_q.dev_sts & ~wdata[3:0];
                A_HDR:     r_d.hdr     = r_q.hdr & ~wdata[0];
                default:   ;
            endcase
        end
        // hardware side: sets take priority over clears in the same cycle
        r_d.cor_sts = r_d.cor_sts | cor_evt;
        r_d.unc_sts = r_d.unc_sts | unc_evt;
        r_d.dev_sts = r_d.dev_sts | det_set;
        r_d.hdr     = r_d.hdr | hdr_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        unique case (addr)
            A_COR_STS: rdata = DW'(r_q.cor_sts);
            A_COR_MSK: rdata = DW'(r_q.cor_msk);
            A_UNC_STS: rdata = DW'(r_q.unc_sts);
            A_UNC_MSK: rdata = DW'(r_q.unc_msk);
            A_UNC_SEV: rdata = DW'(r_q.unc_sev);
            A_CTL:     rdata = DW'(r_q.ctl);
            A_DEV_STS: rdata = DW'(r_q.dev_sts);
            default:   rdata = DW'(r_q.hdr);
        endcase
    end

    assign cor_sts = r_q.cor_sts;
    assign cor_msk = r_q.cor_msk;
    assign unc_sts = r_q.unc_sts;
    assign unc_msk = r_q.unc_msk;
    assign unc_sev = r_q.unc_sev;
    assign ctl     = r_q.ctl;
    assign dev_sts = r_q.dev_sts;
    assign hdr_vld = r_q.hdr;

endmodule

// File: rtl/elog_msg_arb.sv
module elog_msg_arb
    import elog_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCLS-1:0] req,
    input  logic            ready,
    output logic            valid,
    output logic [1:0]      cls
);

    typedef struct packed {
        logic [NCLS-1:0] pend;
    } arb_t;

    arb_t a_d, a_q;
    logic [NCLS-1:0] gnt;
    msg_cls_e        sel;

    always_comb begin
        gnt = '0;
        sel = MSG_COR;
        if (a_q.pend[B_FAT]) begin
            sel        = MSG_FAT;
            gnt[B_FAT] = 1'b1;
        end else if (a_q.pend[B_NF]) begin
            sel       = MSG_NF;
            gnt[B_NF] = 1'b1;
        end else if (a_q.pend[B_COR]) begin
            gnt[B_COR] = 1'b1;
        end
        if (!ready) gnt = '0;
        a_d.pend = (a_q.pend & ~gnt) | req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assign valid = |a_q.pend;
    assign cls   = sel;

endmodule

// File: rtl/err_report_logger.sv
module err_report_logger
    import elog_pkg::*;
#(
    parameter int DW     = 32,
    parameter int NCOR   = 6,
    parameter int NUNC   = 8,
    parameter int UR_IDX = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCOR-1:0] cor_evt_i,
    input  logic [NUNC-1:0] unc_evt_i,
    input  logic [NUNC-1:0] adv_i,
    input  logic            reg_wr_i,
    input  logic [2:0]      reg_addr_i,
    input  logic [DW-1:0]   reg_wdata_i,
    output logic [DW-1:0]   reg_rdata_o,
    output logic            msg_valid_o,
    output logic [1:0]      msg_class_o,
    input  logic            msg_ready_i
);

    logic [NCOR-1:0] cor_sts, cor_msk;
    logic [NUNC-1:0] unc_sts, unc_msk, unc_sev;
    logic [3:0]      ctl, dev_sts, det_set;
    logic [NCLS-1:0] req;
    logic            hdr_set, hdr_vld;

    elog_classify #(.NCOR(NCOR), .NUNC(NUNC), .UR_IDX(UR_IDX)) u_cls (
        .cor_evt (cor_evt_i),
        .unc_evt (unc_evt_i),
        .adv     (adv_i),
        .cor_msk (cor_msk),
        .unc_msk (unc_msk),
        .unc_sev (unc_sev),
        .ctl     (ctl),
        .req     (req),
        .det_set (det_set),
        .hdr_set (hdr_set)
    );

    elog_regs #(.DW(DW), .NCOR(NCOR), .NUNC(NUNC)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr_i),
        .addr    (reg_addr_i),
        .wdata   (reg_wdata_i),
        .cor_evt (cor_evt_i),
        .unc_evt (unc_evt_i),
        .det_set (det_set),
        .hdr_set (hdr_set),
        .rdata   (reg_rdata_o),
        .cor_sts (cor_sts),
        .cor_msk (cor_msk),
        .unc_sts (unc_sts),
        .unc_msk (unc_msk),
        .unc_sev (unc_sev),
        .ctl     (ctl),
        .dev_sts (dev_sts),
        .hdr_vld (hdr_vld)
    );

    elog_msg_arb u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .ready (msg_ready_i),
        .valid (msg_valid_o),
        .cls   (msg_class_o)
    );

endmodule

// File: rtl/elog_chk.sv
module elog_chk
    import elog_pkg::*;
#(
    parameter int NCOR = 6,
    parameter int NUNC = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NCOR-1:0] cor_evt_i,
    input logic [NUNC-1:0] unc_evt_i,
    input logic            reg_wr_i,
    input logic [2:0]      reg_addr_i,
    input logic            msg_valid_o,
    input logic [1:0]      msg_class_o,
    input logic            msg_ready_i,
    input logic [NCOR-1:0] cor_sts,
    input logic [NUNC-1:0] unc_sts,
    input logic [NUNC-1:0] unc_msk,
    input logic [NUNC-1:0] unc_sev,
    input logic [3:0]      ctl,
    input logic            hdr_vld
);

    assert_unc_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (unc_evt_i != '0) |=> ((unc_sts & $past(unc_evt_i)) == $past(unc_evt_i)));

    assert_cor_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cor_evt_i != '0) |=> ((cor_sts & $past(cor_evt_i)) == $past(cor_evt_i)));

    assert_no_silent_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_i && reg_addr_i == A_UNC_STS) |=> ((unc_sts & $past(unc_sts)) == $past(unc_sts)));

    assert_valid_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid_o && !msg_ready_i) |=> msg_valid_o);

    assert_class_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid_o |-> (msg_class_o != 2'b11));

    assert_fatal_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (((unc_evt_i & unc_sev & ~unc_msk) != '0) && ctl[B_FAT])
        |=> (msg_valid_o && msg_class_o == MSG_FAT));

    assert_hdr_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((unc_evt_i & ~unc_msk) != '0) |=> hdr_vld);

endmodule

bind err_report_logger elog_chk #(.NCOR(NCOR), .NUNC(NUNC)) u_chk (.*);

// File: tb/sim_err_report_logger.sv
module sim_err_report_logger;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int NCOR = 6;
    localparam int NUNC = 8;
    localparam int UR = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NCOR-1:0] cev = '0;
    logic [NUNC-1:0] uev = '0;
    logic [NUNC-1:0] adv = '0;
    logic            wr = 1'b0;
    logic [2:0]      addr = '0;
    logic [DW-1:0]   wdata = '0;
    logic [DW-1:0]   rdata;
    logic            mvalid;
    logic [1:0]      mcls;
    logic            rdy = 1'b0;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    // bench model of the programmer-visible state
    logic [NCOR-1:0] m_csts = '0, m_cmsk = '0;
    logic [NUNC-1:0] m_usts = '0, m_umsk = '0, m_sev = '0;
    logic [3:0]      m_ctl = '0, m_dev = '0;
    logic            m_hdr = 1'b0;
    logic [2:0]      m_pend = '0;

    err_report_logger #(.DW(DW), .NCOR(NCOR), .NUNC(NUNC), .UR_IDX(UR)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .cor_evt_i   (cev),
        .unc_evt_i   (uev),
        .adv_i       (adv),
        .reg_wr_i    (wr),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .msg_valid_o (mvalid),
        .msg_class_o (mcls),
        .msg_ready_i (rdy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DW-1:0] mread(input logic [2:0] a);
        case (a)
            3'd0: return DW'(m_csts);
            3'd1: return DW'(m_cmsk);
            3'd2: return DW'(m_usts);
            3'd3: return DW'(m_umsk);
            3'd4: return DW'(m_sev);
            3'd5: return DW'(m_ctl);
            3'd6: return DW'(m_dev);
            default: return DW'(m_hdr);
        endcase
    endfunction

    function automatic logic [1:0] mcls_exp();
        if (m_pend[2]) return 2'd2;
        if (m_pend[1]) return 2'd1;
        return 2'd0;
    endfunction

    function automatic string rtag(input logic [2:0] a);
        case (a)
            3'd0, 3'd2: return "R1 R2";
            3'd6: return "R6";
            3'd7: return "R11";
            default: return "R3";
        endcase
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [DW-1:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    // one clock: compare outputs, advance model, cross the edge
    task automatic cyc();
        logic [2:0] g, rq;
        logic [3:0] dset;
        logic hset;
        logic [NCOR-1:0] n_csts, n_cmsk;
        logic [NUNC-1:0] n_usts, n_umsk, n_sev;
        logic [3:0] n_ctl, n_dev;
        logic n_hdr;
        #1;
        check("R10 valid", DW'(mvalid), DW'(|m_pend));
        if (|m_pend) check("R10 class", DW'(mcls), DW'(mcls_exp()));
        check(rtag(addr), rdata, mread(addr));

        g = '0;
        if (rdy && |m_pend) g = m_pend[2] ? 3'b100 : (m_pend[1] ? 3'b010 : 3'b001);
        rq = '0; dset = '0; hset = 1'b0;
        for (int i = 0; i < NCOR; i++) begin
            if (cev[i]) begin
                dset[0] = 1'b1;
                if (!m_cmsk[i] && m_ctl[0]) rq[0] = 1'b1;
            end
        end
        for (int i = 0; i < NUNC; i++) begin
            if (uev[i]) begin
                if (!m_umsk[i]) hset = 1'b1;
                if (i == UR) dset[3] = 1'b1;
                if (m_sev[i]) begin
                    dset[2] = 1'b1;
                    if (!m_umsk[i] && m_ctl[2]) rq[2] = 1'b1;
                end else if (adv[i]) begin
                    dset[0] = 1'b1;
                    if (!m_umsk[i] && m_ctl[0]) rq[0] = 1'b1;
                end else begin
                    dset[1] = 1'b1;
                    if (!m_umsk[i] && m_ctl[1] && (i != UR || m_ctl[3])) rq[1] = 1'b1;
                end
            end
        end
        n_csts = m_csts; n_cmsk = m_cmsk; n_usts = m_usts; n_umsk = m_umsk;
        n_sev = m_sev; n_ctl = m_ctl; n_dev = m_dev; n_hdr = m_hdr;
        if (wr) begin
            case (addr)
                3'd0: n_csts = m_csts & ~wdata[NCOR-1:0];
                3'd1: n_cmsk = wdata[NCOR-1:0];
                3'd2: n_usts = m_usts & ~wdata[NUNC-1:0];
                3'd3: n_umsk = wdata[NUNC-1:0];
                3'd4: n_sev = wdata[NUNC-1:0];
                3'd5: n_ctl = wdata[3:0];
                3'd6: n_dev = m_dev & ~wdata[3:0];
                default: n_hdr = m_hdr & ~wdata[0];
            endcase
        end
        @(posedge clk);
        m_csts = n_csts | cev; m_cmsk = n_cmsk;
        m_usts = n_usts | uev; m_umsk = n_umsk; m_sev = n_sev;
        m_ctl = n_ctl; m_dev = n_dev | dset; m_hdr = n_hdr | hset;
        m_pend = (m_pend & ~g) | rq;
        @(negedge clk);
        cev = '0; uev = '0; adv = '0; wr = 1'b0; rdy = 1'b0;
    endtask

    task automatic wreg(input logic [2:0] a, input logic [DW-1:0] d);
        wr = 1'b1; addr = a; wdata = d;
        cyc();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        logic [DW-1:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: reset values
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check("R3 reset", v, '0);
        end
        check("R3 no message after reset", DW'(mvalid), '0);

        // R4 R1: masked event logs status, no message, no header flag
        wreg(3'd5, 32'h7);
        wreg(3'd3, 32'hFF);
        uev = 8'h01; cyc();
        rd(3'd2, v); check("R1 masked status set", v, 32'h1);
        check("R4 masked no message", DW'(mvalid), '0);
        rd(3'd7, v); check("R4 masked no header", v, '0);
        // R2: write 0 keeps, write 1 clears, set wins over clear
        wreg(3'd2, 32'h0);
        rd(3'd2, v); check("R2 write zero", v, 32'h1);
        wreg(3'd2, 32'h1);
        rd(3'd2, v); check("R2 write one", v, 32'h0);
        uev = 8'h02; wr = 1'b1; addr = 3'd2; wdata = 32'h2; cyc();
        rd(3'd2, v); check("R2 set beats clear", v, 32'h2);
        wreg(3'd3, 32'h0);
        wreg(3'd6, 32'hF);

        // R7: unsupported request without its own enable
        wreg(3'd5, 32'h2);
        uev = 8'h10; cyc();
        check("R7 gated no message", DW'(mvalid), '0);
        rd(3'd6, v); check("R7 ur and nf detected", v, 32'hA);
        wreg(3'd5, 32'hA);
        uev = 8'h10; cyc();
        check("R7 enabled valid", DW'(mvalid), 32'h1);
        check("R7 enabled class nf", DW'(mcls), 32'h1);
        rdy = 1'b1; cyc();
        check("R10 retired", DW'(mvalid), '0);
        wreg(3'd6, 32'hF);

        // R8: advisory downgrade
        wreg(3'd5, 32'h1);
        uev = 8'h01; adv = 8'h01; cyc();
        check("R8 advisory class cor", DW'(mcls), 32'h0);
        check("R8 advisory valid", DW'(mvalid), 32'h1);
        rd(3'd6, v); check("R8 cor detected only", v, 32'h1);
        rdy = 1'b1; cyc();
        wreg(3'd6, 32'hF);

        // R9: advisory with fatal severity
        wreg(3'd4, 32'h01);
        wreg(3'd5, 32'h5);
        uev = 8'h01; adv = 8'h01; cyc();
        check("R9 fatal class", DW'(mcls), 32'h2);
        rd(3'd6, v); check("R9 fatal detected", v, 32'h4);
        rdy = 1'b1; cyc();

        // R10 R5: three classes at once, drained in priority order
        wreg(3'd5, 32'hF);
        wreg(3'd4, 32'h02);
        uev = 8'h06; cev = 6'h01; cyc();
        check("R5 R10 fatal first", DW'(mcls), 32'h2);
        cyc();
        check("R10 held without ready", DW'(mcls), 32'h2);
        rdy = 1'b1; cyc();
        check("R10 nonfatal second", DW'(mcls), 32'h1);
        rdy = 1'b1; cyc();
        check("R10 correctable third", DW'(mcls), 32'h0);
        rdy = 1'b1; cyc();
        check("R10 drained", DW'(mvalid), '0);

        // random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            cev = NCOR'($urandom & $urandom & $urandom);
            uev = NUNC'($urandom & $urandom & $urandom);
            adv = NUNC'($urandom);
            wr = ($urandom % 5) == 0;
            addr = 3'($urandom);
            wdata = $urandom;
            rdy = $urandom % 2;
            cyc();
        end

        finish_run();
    end

endmodule